// File: doc/BRIEF.md
# Descriptor Chain DMA Channel Controller

This block is the control side of one DMA channel that works through a chain of transfer descriptors kept in system memory. Software sets a source address and a pointer to the first descriptor, turns on the controller-wide enable, and then sets the channel enable. The engine reads each descriptor through a single-outstanding memory read port and hands one buffer transfer to an external datapath over a start/done handshake. When that buffer finishes, it writes the descriptor's first control word back to memory with its completion flag set. It then either follows the next pointer or stops.

A descriptor is five consecutive memory words. Word 0 holds a source address, which is read and then thrown away. Word 1 is the destination address. Word 2 is the next pointer. Word 3 is control word A: bits [15:0] give the buffer length and bit 31 is the completion flag. Word 4 is control word B: bit 0 set means the chain continues. The source address is not reloaded from descriptors. It advances by each buffer's length, so the source stays contiguous across the whole chain.

A descriptor pointer is a word address in bits [AW:1] and a memory layer select in bit 0. A pointer value of zero means no further descriptor. When the last write-back completes, the channel enable clears itself and the interrupt line rises. Reading the status register returns the pending flag and clears it.

Top module: `dma_chain_engine`

## Requirements
- R1: Each descriptor fetch issues exactly five reads, to pointer address +0, +1, +2, +3, +4 in that order, all on the layer given by pointer bit 0.
- R2: Descriptor word 0 has no effect. The first buffer's source is the source register value written by software, and each later buffer's source is the previous source plus the previous length.
- R3: Each buffer transfer carries descriptor word 1 as destination and word 3 bits [15:0] as length.
- R4: The next descriptor is fetched only when word 2 bits [AW:0] are non-zero and word 4 bit 0 is 1. Otherwise the chain ends after the current buffer, and no further reads occur.
- R5: After each buffer's done, one write goes to pointer address +3 on the same layer, with data equal to the fetched word 3 with bit 31 set. It comes before any read of the next descriptor.
- R6: A channel starts only while both the global enable (address 0, bit 0) and the channel enable (address 1, bit 0, set by writing 1) are on. A channel enable written while the global enable is off waits with no memory or transfer activity. Writing 0 to address 1 has no effect.
- R7: After the last write-back of a chain, the channel enable reads back 0 and the interrupt output goes high.
- R8: A read of the status register (address 4) returns the pending flag in bit 0 and clears it, so the interrupt output drops and a second read returns 0.
- R9: A memory request keeps valid, address, direction and data unchanged until ready is seen. No new request is issued while a read response is outstanding.
- R10: Address 2 reads back the current source address and address 3 the current descriptor pointer. Read data appears one cycle after the read strobe, and all registers and outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle after cfg_re |
| irq | output | 1 | Chain-complete interrupt |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | AW | Word address |
| mem_req_layer | output | 1 | Memory layer select |
| mem_req_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| xfer_start | output | 1 | One-cycle pulse starting a buffer transfer |
| xfer_src | output | 32 | Buffer source address |
| xfer_dst | output | 32 | Buffer destination address |
| xfer_len | output | 16 | Buffer length |
| xfer_done | input | 1 | Datapath reports buffer complete |

## Verification
Faults in the sequencing show up quickly at the memory port. A wrong fetch index or a wrong layer latch gives a read to a bad address within one descriptor fetch. A broken chain decision shows up as an extra or missing read straight after the write-back. A corrupted source accumulator is hidden until the second buffer of a chain, which then starts at the wrong source. Faults in the enable or interrupt bookkeeping only appear at chain end: the enable fails to clear, the interrupt stays low, or the status read fails to clear it.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int DESC_WORDS = 5;
  localparam logic [2:0] IDX_SRC  = 3'd0;
  localparam logic [2:0] IDX_DST  = 3'd1;
  localparam logic [2:0] IDX_NEXT = 3'd2;
  localparam logic [2:0] IDX_CTLA = 3'd3;
  localparam logic [2:0] IDX_CTLB = 3'd4;
  localparam int DONE_BIT  = 31;
  localparam int CHAIN_BIT = 0;

  localparam logic [2:0] RA_GLOBAL = 3'd0;
  localparam logic [2:0] RA_CHEN   = 3'd1;
  localparam logic [2:0] RA_SRC    = 3'd2;
  localparam logic [2:0] RA_DESC   = 3'd3;
  localparam logic [2:0] RA_STAT   = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FREQ, ST_FWAIT, ST_XGO, ST_XWAIT, ST_WREQ, ST_WWAIT, ST_FIN
  } chain_state_e;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_chain_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_re,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          glob_en,
  output logic          ch_en,
  output logic [DW-1:0] src_addr,
  output logic [PW-1:0] desc_ptr,
  output logic          irq,
  input  logic          src_adv,
  input  logic [DW-1:0] src_new,
  input  logic          ptr_load,
  input  logic [PW-1:0] ptr_new,
  input  logic          finish
);
  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en   <= 1'b0;
      ch_en     <= 1'b0;
      src_addr  <= '0;
      desc_ptr  <= '0;
      irq       <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_we && cfg_addr == RA_GLOBAL) glob_en <= cfg_wdata[0];
      if (finish) ch_en <= 1'b0;
      else if (cfg_we && cfg_addr == RA_CHEN && cfg_wdata[0]) ch_en <= 1'b1;
      if (src_adv) src_addr <= src_new;
      else if (cfg_we && cfg_addr == RA_SRC) src_addr <= cfg_wdata;
      if (ptr_load) desc_ptr <= ptr_new;
      else if (cfg_we && cfg_addr == RA_DESC) desc_ptr <= cfg_wdata[PW-1:0];
      if (finish) irq <= 1'b1;
      else if (cfg_re && cfg_addr == RA_STAT) irq <= 1'b0;
      if (cfg_re) begin
        case (cfg_addr)
          RA_GLOBAL: cfg_rdata <= {{(DW-1){1'b0}}, glob_en};
          RA_CHEN:   cfg_rdata <= {{(DW-1){1'b0}}, ch_en};
          RA_SRC:    cfg_rdata <= src_addr;
          RA_DESC:   cfg_rdata <= {{(DW-PW){1'b0}}, desc_ptr};
          RA_STAT:   cfg_rdata <= {{(DW-1){1'b0}}, irq};
          default:   cfg_rdata <= '0;
        endcase
      end
    end
  end

  p_irq_end_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !ch_en);

  p_stat_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_re && cfg_addr == RA_STAT && !finish) |=> !irq);
endmodule

// File: rtl/dma_mem_port.sv
module dma_mem_port #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_go,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic          cmd_layer,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic          mem_req_layer,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  localparam logic [1:0] P_IDLE = 2'd0;
  localparam logic [1:0] P_REQ  = 2'd1;
  localparam logic [1:0] P_RESP = 2'd2;

  logic [1:0] pst_q;

  always_ff @(posedge clk) begin
    rsp_done <= 1'b0;
    if (rst) begin
      pst_q         <= P_IDLE;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_layer <= 1'b0;
      mem_req_wdata <= '0;
      rsp_data      <= '0;
    end else begin
      case (pst_q)
        P_IDLE: if (cmd_go) begin
          mem_req_valid <= 1'b1;
          mem_req_write <= cmd_write;
          mem_req_addr  <= cmd_addr;
          mem_req_layer <= cmd_layer;
          mem_req_wdata <= cmd_wdata;
          pst_q         <= P_REQ;
        end
        P_REQ: if (mem_req_ready) begin
          mem_req_valid <= 1'b0;
          if (mem_req_write) begin
            rsp_done <= 1'b1;
            pst_q    <= P_IDLE;
          end else begin
            pst_q <= P_RESP;
          end
        end
        P_RESP: if (mem_rvalid) begin
          rsp_data <= mem_rdata;
          rsp_done <= 1'b1;
          pst_q    <= P_IDLE;
        end
        default: pst_q <= P_IDLE;
      endcase
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
       && $stable(mem_req_layer) && $stable(mem_req_wdata)));

  p_single_out_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready && !mem_req_write) |=> !mem_req_valid);
endmodule

// File: rtl/dma_chain_fsm.sv
module dma_chain_fsm
  import dma_chain_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LEN_W = 16,
  localparam int PW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ch_en,
  input  logic             glob_en,
  input  logic [DW-1:0]    src_addr,
  input  logic [PW-1:0]    desc_ptr,
  output logic             cmd_go,
  output logic             cmd_write,
  output logic [AW-1:0]    cmd_addr,
  output logic             cmd_layer,
  output logic [DW-1:0]    cmd_wdata,
  input  logic             rsp_done,
  input  logic [DW-1:0]    rsp_data,
  output logic             xfer_start,
  output logic [DW-1:0]    xfer_src,
  output logic [DW-1:0]    xfer_dst,
  output logic [LEN_W-1:0] xfer_len,
  input  logic             xfer_done,
  output logic             src_adv,
  output logic [DW-1:0]    src_new,
  output logic             ptr_load,
  output logic [PW-1:0]    ptr_new,
  output logic             finish
);
  chain_state_e  state_q;
  logic [2:0]    idx_q;
  logic [AW-1:0] base_q;
  logic          layer_q;
  logic [DW-1:0] dst_q;
  logic [PW-1:0] next_q;
  logic [DW-1:0] ctla_q;
  logic          chain_q;

  always_ff @(posedge clk) begin
    cmd_go     <= 1'b0;
    xfer_start <= 1'b0;
    src_adv    <= 1'b0;
    ptr_load   <= 1'b0;
    finish     <= 1'b0;
    if (rst) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      base_q    <= '0;
      layer_q   <= 1'b0;
      dst_q     <= '0;
      next_q    <= '0;
      ctla_q    <= '0;
      chain_q   <= 1'b0;
      cmd_write <= 1'b0;
      cmd_addr  <= '0;
      cmd_layer <= 1'b0;
      cmd_wdata <= '0;
      xfer_src  <= '0;
      xfer_dst  <= '0;
      xfer_len  <= '0;
      src_new   <= '0;
      ptr_new   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (ch_en && glob_en) begin
          base_q  <= desc_ptr[PW-1:1];
          layer_q <= desc_ptr[0];
          idx_q   <= '0;
          state_q <= ST_FREQ;
        end
        ST_FREQ: begin
          cmd_go    <= 1'b1;
          cmd_write <= 1'b0;
          cmd_addr  <= base_q + AW'(idx_q);
          cmd_layer <= layer_q;
          state_q   <= ST_FWAIT;
        end
        ST_FWAIT: if (rsp_done) begin
          case (idx_q)
            IDX_DST:  dst_q   <= rsp_data;
            IDX_NEXT: next_q  <= rsp_data[PW-1:0];
            IDX_CTLA: ctla_q  <= rsp_data;
            IDX_CTLB: chain_q <= rsp_data[CHAIN_BIT];
            default: ;
          endcase
          if (idx_q == 3'(DESC_WORDS - 1)) begin
            state_q <= ST_XGO;
          end else begin
            idx_q   <= idx_q + 3'd1;
            state_q <= ST_FREQ;
          end
        end
        ST_XGO: begin
          xfer_start <= 1'b1;
          xfer_src   <= src_addr;
          xfer_dst   <= dst_q;
          xfer_len   <= ctla_q[LEN_W-1:0];
          state_q    <= ST_XWAIT;
        end
        ST_XWAIT: if (xfer_done) begin
          src_adv <= 1'b1;
          src_new <= src_addr + DW'(xfer_len);
          state_q <= ST_WREQ;
        end
        ST_WREQ: begin
          cmd_go    <= 1'b1;
          cmd_write <= 1'b1;
          cmd_addr  <= base_q + AW'(IDX_CTLA);
          cmd_layer <= layer_q;
          cmd_wdata <= ctla_q | (DW'(1) << DONE_BIT);
          state_q   <= ST_WWAIT;
        end
        ST_WWAIT: if (rsp_done) begin
          if (next_q != '0 && chain_q) begin
            base_q   <= next_q[PW-1:1];
            layer_q  <= next_q[0];
            ptr_load <= 1'b1;
            ptr_new  <= next_q;
            idx_q    <= '0;
            state_q  <= ST_FREQ;
          end else begin
            finish  <= 1'b1;
            state_q <= ST_FIN;
          end
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_start_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FREQ && $past(state_q) == ST_IDLE) |-> $past(glob_en && ch_en));

  p_wb_after_done_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WREQ) |-> $past(xfer_done));
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LEN_W = 16,
  localparam int PW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_re,
  input  logic [2:0]       cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  output logic             irq,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [AW-1:0]    mem_req_addr,
  output logic             mem_req_layer,
  output logic [DW-1:0]    mem_req_wdata,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             xfer_start,
  output logic [DW-1:0]    xfer_src,
  output logic [DW-1:0]    xfer_dst,
  output logic [LEN_W-1:0] xfer_len,
  input  logic             xfer_done
);
  logic          glob_en, ch_en;
  logic [DW-1:0] src_addr, src_new;
  logic [PW-1:0] desc_ptr, ptr_new;
  logic          src_adv, ptr_load, finish;
  logic          cmd_go, cmd_write, cmd_layer, rsp_done;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata, rsp_data;

  dma_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .glob_en(glob_en), .ch_en(ch_en), .src_addr(src_addr),
    .desc_ptr(desc_ptr), .irq(irq), .src_adv(src_adv), .src_new(src_new),
    .ptr_load(ptr_load), .ptr_new(ptr_new), .finish(finish)
  );

  dma_chain_fsm #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst(rst), .ch_en(ch_en), .glob_en(glob_en),
    .src_addr(src_addr), .desc_ptr(desc_ptr), .cmd_go(cmd_go),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_layer(cmd_layer),
    .cmd_wdata(cmd_wdata), .rsp_done(rsp_done), .rsp_data(rsp_data),
    .xfer_start(xfer_start), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
    .xfer_len(xfer_len), .xfer_done(xfer_done), .src_adv(src_adv),
    .src_new(src_new), .ptr_load(ptr_load), .ptr_new(ptr_new),
    .finish(finish)
  );

  dma_mem_port #(.AW(AW), .DW(DW)) u_port (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_layer(cmd_layer), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_layer(mem_req_layer), .mem_req_wdata(mem_req_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  p_wb_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[DW-1]);

  p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_valid) |-> ch_en);
endmodule

// File: tb/dma_chain_engine_bench.sv
module dma_chain_engine_bench;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NLOG = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_re = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic irq;
  logic mem_req_valid, mem_req_write, mem_req_layer;
  logic mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic mem_rvalid;
  logic [DW-1:0] mem_rdata;
  logic xfer_start, xfer_done;
  logic [DW-1:0] xfer_src, xfer_dst;
  logic [15:0] xfer_len;

  always #5 clk = ~clk;

  dma_chain_engine u_dma_chain_engine (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq(irq), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_layer(mem_req_layer), .mem_req_wdata(mem_req_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .xfer_start(xfer_start), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
    .xfer_len(xfer_len), .xfer_done(xfer_done)
  );

  // memory model with back-door load port
  logic [DW-1:0] mem0 [0:255];
  logic [DW-1:0] mem1 [0:255];
  logic bd_we = 1'b0, bd_layer = 1'b0;
  logic [AW-1:0] bd_addr = '0;
  logic [DW-1:0] bd_data = '0;
  int rd_cnt;
  logic [DW-1:0] rd_hold;
  int op_n;
  logic op_w [0:NLOG-1];
  logic [AW-1:0] op_addr [0:NLOG-1];
  logic op_layer [0:NLOG-1];
  logic [DW-1:0] op_data [0:NLOG-1];

  always @(posedge clk) begin
    if (rst) begin
      mem_req_ready <= 1'b0;
      mem_rvalid <= 1'b0;
      mem_rdata <= '0;
      rd_cnt <= 0;
      op_n <= 0;
    end else begin
      mem_req_ready <= ($urandom % 3) != 0;
      mem_rvalid <= 1'b0;
      if (bd_we) begin
        if (bd_layer) mem1[bd_addr] <= bd_data; else mem0[bd_addr] <= bd_data;
      end
      if (rd_cnt != 0) begin
        rd_cnt <= rd_cnt - 1;
        if (rd_cnt == 1) begin
          mem_rvalid <= 1'b1;
          mem_rdata <= rd_hold;
        end
      end
      if (mem_req_valid && mem_req_ready) begin
        op_w[op_n % NLOG] <= mem_req_write;
        op_addr[op_n % NLOG] <= mem_req_addr;
        op_layer[op_n % NLOG] <= mem_req_layer;
        op_data[op_n % NLOG] <= mem_req_wdata;
        op_n <= op_n + 1;
        if (mem_req_write) begin
          if (mem_req_layer) mem1[mem_req_addr] <= mem_req_wdata;
          else mem0[mem_req_addr] <= mem_req_wdata;
        end else begin
          rd_hold <= mem_req_layer ? mem1[mem_req_addr] : mem0[mem_req_addr];
          rd_cnt <= 1 + int'($urandom % 3);
        end
      end
    end
  end

  // datapath stub
  int xf_n, xf_cnt;
  logic [DW-1:0] xf_src [0:NLOG-1];
  logic [DW-1:0] xf_dst [0:NLOG-1];
  logic [15:0] xf_len [0:NLOG-1];

  always @(posedge clk) begin
    if (rst) begin
      xfer_done <= 1'b0;
      xf_n <= 0;
      xf_cnt <= 0;
    end else begin
      xfer_done <= 1'b0;
      if (xf_cnt != 0) begin
        xf_cnt <= xf_cnt - 1;
        if (xf_cnt == 1) xfer_done <= 1'b1;
      end
      if (xfer_start) begin
        xf_src[xf_n % NLOG] <= xfer_src;
        xf_dst[xf_n % NLOG] <= xfer_dst;
        xf_len[xf_n % NLOG] <= xfer_len;
        xf_n <= xf_n + 1;
        xf_cnt <= 1 + int'($urandom % 5);
      end
    end
  end

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_re = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic bd_wr(input logic l, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_layer = l; bd_addr = a; bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  function automatic logic [DW-1:0] wb_expect(input logic [DW-1:0] a);
    return a | 32'h8000_0000;
  endfunction

  function automatic logic [DW-1:0] ptr_enc(input logic [AW-1:0] a, input logic l);
    return {{(DW-AW-1){1'b0}}, a, l};
  endfunction

  // stop_kind 0: natural end at last; 1: chain bit 0 at stop_at with next set;
  // 2: next zero at stop_at with chain bit 1
  task automatic run_chain(input int nb, input int stop_kind, input int stop_at,
                           input bit gate_test);
    logic [AW-1:0] da [0:7];
    logic dl [0:7];
    logic [DW-1:0] dd [0:7];
    logic [DW-1:0] ca [0:7];
    logic [DW-1:0] src0, s, v;
    int np, op0, xf0, wait_n;
    int off;
    off = int'($urandom % 4);
    for (int k = 0; k < nb; k++) begin
      da[k] = AW'(16 * (k + 1) + off);
      dl[k] = 1'($urandom % 2);
      dd[k] = $urandom;
      ca[k] = {1'b0, 15'($urandom), 16'(1 + $urandom % 40)};
    end
    np = (stop_kind == 0) ? nb : stop_at + 1;
    for (int k = 0; k < nb; k++) begin
      logic [DW-1:0] nx, cb;
      bit last;
      last = (stop_kind == 0) ? (k == nb - 1) : (k == stop_at);
      nx = (k == nb - 1) ? '0 : ptr_enc(da[k+1], dl[k+1]);
      cb = {$urandom, 1'b0} | 32'(!last || stop_kind == 2);
      if (last && stop_kind == 2) nx = '0;
      if (last && stop_kind == 0) cb[0] = 1'b0;
      bd_wr(dl[k], da[k] + 0, $urandom);
      bd_wr(dl[k], da[k] + 1, dd[k]);
      bd_wr(dl[k], da[k] + 2, nx);
      bd_wr(dl[k], da[k] + 3, ca[k]);
      bd_wr(dl[k], da[k] + 4, cb);
    end
    src0 = $urandom;
    reg_wr(3'd2, src0);
    reg_wr(3'd3, ptr_enc(da[0], dl[0]));
    reg_rd(3'd3, v);
    chk(v == ptr_enc(da[0], dl[0]), "R10 desc ptr readback", v, ptr_enc(da[0], dl[0]));
    op0 = op_n; xf0 = xf_n;
    if (gate_test) begin
      reg_wr(3'd0, 32'h0);
      reg_wr(3'd1, 32'h1);
      repeat (40) @(negedge clk);
      chk(op_n == op0 && xf_n == xf0, "R6 no activity while global off",
          32'(op_n - op0), 32'h0);
      reg_rd(3'd1, v);
      chk(v == 32'h1, "R6 channel enable pending", v, 32'h1);
      reg_wr(3'd0, 32'h1);
    end else begin
      reg_wr(3'd1, 32'h0);
      repeat (20) @(negedge clk);
      chk(op_n == op0, "R6 writing 0 does not start", 32'(op_n - op0), 32'h0);
      reg_wr(3'd1, 32'h1);
    end
    wait_n = 0;
    while (!irq && wait_n < 20000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(irq == 1'b1, "R7 interrupt raised", 32'(irq), 32'h1);
    repeat (10) @(negedge clk);
    chk(op_n - op0 == 6 * np, "R4 memory op count", 32'(op_n - op0), 32'(6 * np));
    chk(xf_n - xf0 == np, "R4 buffer count", 32'(xf_n - xf0), 32'(np));
    s = src0;
    for (int k = 0; k < np; k++) begin
      for (int i = 0; i < 5; i++) begin
        int j;
        j = (op0 + 6 * k + i) % NLOG;
        chk(!op_w[j] && op_addr[j] == da[k] + AW'(i) && op_layer[j] == dl[k],
            "R1 fetch order", {op_w[j], 22'd0, op_layer[j], op_addr[j]},
            {1'b0, 22'd0, dl[k], da[k] + AW'(i)});
      end
      begin
        int j;
        j = (op0 + 6 * k + 5) % NLOG;
        chk(op_w[j] && op_addr[j] == da[k] + 3 && op_layer[j] == dl[k],
            "R5 write-back address", {op_w[j], 22'd0, op_layer[j], op_addr[j]},
            {1'b1, 22'd0, dl[k], da[k] + AW'(3)});
        chk(op_data[j] == wb_expect(ca[k]), "R5 write-back data", op_data[j],
            wb_expect(ca[k]));
      end
      chk(xf_src[(xf0 + k) % NLOG] == s, "R2 contiguous source",
          xf_src[(xf0 + k) % NLOG], s);
      chk(xf_dst[(xf0 + k) % NLOG] == dd[k], "R3 destination",
          xf_dst[(xf0 + k) % NLOG], dd[k]);
      chk(xf_len[(xf0 + k) % NLOG] == ca[k][15:0], "R3 length",
          32'(xf_len[(xf0 + k) % NLOG]), 32'(ca[k][15:0]));
      s = s + 32'(ca[k][15:0]);
    end
    reg_rd(3'd1, v);
    chk(v == 32'h0, "R7 channel enable self-clears", v, 32'h0);
    reg_rd(3'd2, v);
    chk(v == s, "R2 source register advanced", v, s);
    reg_rd(3'd4, v);
    chk(v == 32'h1, "R8 status shows pending", v, 32'h1);
    @(negedge clk);
    chk(irq == 1'b0, "R8 interrupt cleared by read", 32'(irq), 32'h0);
    reg_rd(3'd4, v);
    chk(v == 32'h0, "R8 second status read", v, 32'h0);
  endtask

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0 && !mem_req_valid && !xfer_start, "R10 reset outputs",
        {29'd0, irq, mem_req_valid, xfer_start}, 32'h0);
    for (int a = 0; a < 5; a++) begin
      reg_rd(3'(a), v);
      chk(v == 32'h0, "R10 reset register", v, 32'h0);
    end
    run_chain(2, 0, 1, 1'b1);
    for (int t = 0; t < 5; t++) run_chain(1 + int'($urandom % 6), 0, 0, 1'b0);
    run_chain(4, 1, 0, 1'b0);
    run_chain(4, 2, 1, 1'b0);
    run_chain(5, 1, 2, 1'b0);
    run_chain(1, 0, 0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule